// File: doc/BRIEF.md
# HDLC Receive Queue Manager

This block sits between an HDLC deframer and a processor on a low-rate data link. The deframer delivers received bytes one at a time. Each byte is marked as payload or as part of the frame check sequence. A separate end-of-frame event carries the frame's error indications: checksum failure, abort and a length that is not a whole number of bytes. The block stores the bytes in a 64-entry byte-wide queue and drains it through a show-ahead read port. After the last stored byte of every frame it appends a frame-status byte. One queue can therefore hold several frames, each ending in its own status byte.

The processor sees five things about the queue. The first is a queue count, which stops at the oldest status byte. The second is a flag that is high while any status byte is queued. The other three are sticky flags for fill threshold, frame completion and overrun, all cleared by one status-read strobe. A separate detector on the raw receive bitstream shows a live idle indication. When a byte or a status byte arrives while the queue is full, the newest entry is replaced by a status byte marking the overrun.

Frame handling is a two-state machine. `RQ_ACCEPT` is the normal state. There, an end event writes a status byte, and a byte that fits the queue is stored. A byte that arrives on a full queue overwrites the newest entry and moves the machine to `RQ_DISCARD`. In `RQ_DISCARD` all bytes are dropped. The next end event is consumed without writing anything and returns the machine to `RQ_ACCEPT`.

Top module: `hdlc_rx_queue`

## Requirements
- R1: A frame of n stored bytes occupies n+1 queue entries: the bytes in arrival order, then one status byte. The queue holds at most 64 entries.
- R2: A byte marked as checksum is discarded when `cfg_pass_crc` is 0. It is stored as an ordinary byte, after the payload bytes, when `cfg_pass_crc` is 1.
- R3: Status byte encoding: bit 7 is checksum failure, bit 6 is abort, bit 5 is queue overrun, bit 4 is bad byte count, and bits 3..0 are zero. An error-free frame therefore ends in 8'h00.
- R4: `eof_present` is 1 exactly while at least one status byte is held in the queue.
- R5: `queue_count` gives the 1-based position of the oldest status byte in the queue. With no status byte queued, it gives the number of stored bytes. It stays correct while several queued frames are read out one after another.
- R6: `fill_flag` is set one cycle after the occupancy becomes at least `cfg_fill_level`. It stays set while the occupancy remains at or above that level. Otherwise it clears on `status_rd`.
- R7: `frame_flag` is set by the write of a frame's status byte and is cleared by `status_rd`.
- R8: When a byte or a status byte arrives while the queue is full and not being read, three things happen. `overrun_flag` is set (sticky, cleared by `status_rd`). The newest entry is overwritten with a status byte that has bit 5 set. The remaining bytes of that frame, and its end event, are dropped.
- R9: `idle_flag` is 1 while the last 15 or more valid bits on the receive bitstream were all 1. A valid 0 bit clears it.
- R10: A read of an empty queue returns 8'h00 and changes neither the count nor any later read result.
- R11: After reset the queue is empty: count 0, `eof_present` 0, all flags 0, `rd_data` 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte_valid | input | 1 | A received byte is presented (ignored if `rx_end_valid` is high) |
| rx_byte | input | 8 | Received byte |
| rx_byte_is_crc | input | 1 | The byte belongs to the frame check sequence |
| rx_end_valid | input | 1 | End-of-frame event |
| rx_end_bad_crc | input | 1 | Frame failed its checksum |
| rx_end_abort | input | 1 | Frame was aborted |
| rx_end_bad_count | input | 1 | Frame length was not a whole number of bytes |
| rx_bit_valid | input | 1 | A raw receive bit is presented |
| rx_bit | input | 1 | Raw receive bit |
| cfg_pass_crc | input | 1 | Store checksum bytes as data |
| cfg_fill_level | input | 6 | Occupancy threshold for `fill_flag` |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 8 | Head entry (show-ahead), 8'h00 when empty |
| status_rd | input | 1 | Status read strobe, clears sticky flags |
| queue_count | output | 7 | Entries up to and including the oldest status byte |
| eof_present | output | 1 | A status byte is queued |
| fill_flag | output | 1 | Sticky fill-threshold flag |
| frame_flag | output | 1 | Sticky frame-written flag |
| overrun_flag | output | 1 | Sticky overrun flag |
| idle_flag | output | 1 | 15 or more consecutive 1 bits seen |

## Verification
The overrun path is the hardest case to reach. It needs the queue completely full of one unfinished frame, so that no earlier status byte can mask the overwrite. The bench pushes 64 bytes of one frame without reading. It then offers one more byte, and after that more bytes and an end event that must all be dropped. Finally it drains the queue: the 64th entry must be the overrun status byte, and a following frame must be stored normally. Several frames are also queued at once, so that the count has to move from one status byte to the next during reads.

// File: rtl/hrq_pkg.sv
package hrq_pkg;

    // Bit positions inside the frame-status byte
    localparam int SF_BAD_CRC   = 7;
    localparam int SF_ABORT     = 6;
    localparam int SF_OVERRUN   = 5;
    localparam int SF_BAD_COUNT = 4;

    typedef enum logic [0:0] {
        RQ_ACCEPT  = 1'b0,
        RQ_DISCARD = 1'b1
    } rq_state_e;

    typedef struct packed {
        logic       is_status;
        logic [7:0] value;
    } rq_entry_t;

endpackage

// File: rtl/hrq_store.sv
module hrq_store
    import hrq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              overwrite,
    input  logic              pop,
    input  rq_entry_t         wr_entry,
    output logic [7:0]        head_value,
    output logic [CW-1:0]     occupancy,
    output logic [DEPTH-1:0]  tag_vec,
    output logic [AW-1:0]     head_ptr,
    output logic [CW-1:0]     status_total
);

    logic [7:0]       mem_q [DEPTH];
    logic [DEPTH-1:0] tag_q;
    logic [AW-1:0]    wr_ptr_q;
    logic [AW-1:0]    rd_ptr_q;
    logic [CW-1:0]    occ_q;
    logic [CW-1:0]    stat_q;
    logic [AW-1:0]    last_ptr;
    logic             stat_inc;
    logic             stat_dec_pop;
    logic             stat_dec_ovw;

    assign last_ptr = wr_ptr_q - 1'b1;

    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[wr_ptr_q] <= wr_entry.value;
        end else if (overwrite) begin
            mem_q[last_ptr] <= wr_entry.value;
        end
    end

    assign stat_inc     = (push && wr_entry.is_status) ||
                          (overwrite && wr_entry.is_status && !tag_q[last_ptr]);
    assign stat_dec_ovw = overwrite && !wr_entry.is_status && tag_q[last_ptr];
    assign stat_dec_pop = pop && tag_q[rd_ptr_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q    <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            occ_q    <= '0;
            stat_q   <= '0;
        end else begin
            if (push) begin
                tag_q[wr_ptr_q] <= wr_entry.is_status;
                wr_ptr_q        <= wr_ptr_q + 1'b1;
            end else if (overwrite) begin
                tag_q[last_ptr] <= wr_entry.is_status;
            end
            if (pop) begin
                rd_ptr_q <= rd_ptr_q + 1'b1;
            end
            occ_q  <= occ_q + CW'(push) - CW'(pop);
            stat_q <= stat_q + CW'(stat_inc) - CW'(stat_dec_pop) - CW'(stat_dec_ovw);
        end
    end

    assign head_value   = (occ_q != '0) ? mem_q[rd_ptr_q] : 8'h00;
    assign occupancy    = occ_q;
    assign tag_vec      = tag_q;
    assign head_ptr     = rd_ptr_q;
    assign status_total = stat_q;

    // R1: a push never lands on a full queue unless a pop frees a slot
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (occ_q != CW'(DEPTH) || pop));

    // R10: a pop is only issued against a non-empty queue
    p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> occ_q != '0);

    // R8: an overwrite leaves the occupancy unchanged
    p_overwrite_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overwrite && !pop) |=> occ_q == $past(occ_q));

endmodule

// File: rtl/hrq_first_mark.sv
module hrq_first_mark #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] tag_vec,
    input  logic [AW-1:0]    head_ptr,
    input  logic [CW-1:0]    occupancy,
    input  logic [CW-1:0]    status_total,
    output logic [CW-1:0]    queue_count
);

    // Scan from the head for the oldest status entry among the live ones
    always_comb begin
        logic          found;
        logic [AW-1:0] idx;
        found       = 1'b0;
        queue_count = occupancy;
        for (int i = 0; i < DEPTH; i++) begin
            idx = head_ptr + AW'(i);
            if (!found && (CW'(i) < occupancy) && tag_vec[idx]) begin
                found       = 1'b1;
                queue_count = CW'(i + 1);
            end
        end
    end

    // R5: the reported count never exceeds what is stored
    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        queue_count <= occupancy);

    // R5: with a status entry queued the count points at a real entry
    p_count_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_total != '0) |-> queue_count != '0);

endmodule

// File: rtl/hrq_idle_det.sv
module hrq_idle_det #(
    parameter int RUN  = 15,
    localparam int RW  = $clog2(RUN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    output logic idle
);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (bit_valid) begin
            if (!bit_in) begin
                run_q <= '0;
            end else if (run_q != RW'(RUN)) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign idle = (run_q == RW'(RUN));

    // R9: a valid zero bit always ends the idle indication
    p_idle_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && !bit_in) |=> !idle);

    // R9: idle only rises on a valid one bit
    p_idle_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> $past(bit_valid && bit_in));

endmodule

// File: rtl/hdlc_rx_queue.sv
module hdlc_rx_queue
    import hrq_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int LEVEL_W  = 6,
    parameter int IDLE_RUN = 15,
    localparam int AW      = $clog2(DEPTH),
    localparam int CW      = AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_byte_valid,
    input  logic [7:0]         rx_byte,
    input  logic               rx_byte_is_crc,
    input  logic               rx_end_valid,
    input  logic               rx_end_bad_crc,
    input  logic               rx_end_abort,
    input  logic               rx_end_bad_count,
    input  logic               rx_bit_valid,
    input  logic               rx_bit,
    input  logic               cfg_pass_crc,
    input  logic [LEVEL_W-1:0] cfg_fill_level,
    input  logic               rd_en,
    output logic [7:0]         rd_data,
    input  logic               status_rd,
    output logic [CW-1:0]      queue_count,
    output logic               eof_present,
    output logic               fill_flag,
    output logic               frame_flag,
    output logic               overrun_flag,
    output logic               idle_flag
);

    rq_state_e        state_q, state_d;
    rq_entry_t        wr_entry;
    logic             push, overwrite, pop, room, byte_take;
    logic             frame_set, ovr_set;
    logic [7:0]       end_status;
    logic [CW-1:0]    occupancy, status_total;
    logic [DEPTH-1:0] tag_vec;
    logic [AW-1:0]    head_ptr;
    logic             fill_q, frame_q, ovr_q;

    assign pop       = rd_en && (occupancy != '0);
    assign room      = (occupancy != CW'(DEPTH)) || pop;
    assign byte_take = rx_byte_valid && (!rx_byte_is_crc || cfg_pass_crc);

    always_comb begin
        end_status                = 8'h00;
        end_status[SF_BAD_CRC]    = rx_end_bad_crc;
        end_status[SF_ABORT]      = rx_end_abort;
        end_status[SF_BAD_COUNT]  = rx_end_bad_count;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RQ_ACCEPT;
        end else begin
            state_q <= state_d;
        end
    end

    // Transition and write decisions
    always_comb begin
        state_d   = state_q;
        push      = 1'b0;
        overwrite = 1'b0;
        frame_set = 1'b0;
        ovr_set   = 1'b0;
        wr_entry  = '0;
        unique case (state_q)
            RQ_ACCEPT: begin
                if (rx_end_valid) begin
                    wr_entry.is_status = 1'b1;
                    wr_entry.value     = end_status;
                    frame_set          = 1'b1;
                    if (room) begin
                        push = 1'b1;
                    end else begin
                        overwrite                  = 1'b1;
                        ovr_set                    = 1'b1;
                        wr_entry.value[SF_OVERRUN] = 1'b1;
                    end
                end else if (byte_take) begin
                    if (room) begin
                        push           = 1'b1;
                        wr_entry.value = rx_byte;
                    end else begin
                        overwrite                  = 1'b1;
                        ovr_set                    = 1'b1;
                        wr_entry.is_status         = 1'b1;
                        wr_entry.value[SF_OVERRUN] = 1'b1;
                        state_d                    = RQ_DISCARD;
                    end
                end
            end
            RQ_DISCARD: begin
                if (rx_end_valid) begin
                    state_d = RQ_ACCEPT;
                end
            end
            default: state_d = RQ_ACCEPT;
        endcase
    end

    // Sticky flags: a set in the same cycle wins over the clearing read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q  <= 1'b0;
            frame_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            fill_q  <= (occupancy >= CW'(cfg_fill_level)) || (fill_q && !status_rd);
            frame_q <= frame_set || (frame_q && !status_rd);
            ovr_q   <= ovr_set   || (ovr_q   && !status_rd);
        end
    end

    hrq_store #(.DEPTH(DEPTH)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .push         (push),
        .overwrite    (overwrite),
        .pop          (pop),
        .wr_entry     (wr_entry),
        .head_value   (rd_data),
        .occupancy    (occupancy),
        .tag_vec      (tag_vec),
        .head_ptr     (head_ptr),
        .status_total (status_total)
    );

    hrq_first_mark #(.DEPTH(DEPTH)) u_mark (
        .clk          (clk),
        .rst_n        (rst_n),
        .tag_vec      (tag_vec),
        .head_ptr     (head_ptr),
        .occupancy    (occupancy),
        .status_total (status_total),
        .queue_count  (queue_count)
    );

    hrq_idle_det #(.RUN(IDLE_RUN)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (rx_bit_valid),
        .bit_in    (rx_bit),
        .idle      (idle_flag)
    );

    assign eof_present  = (status_total != '0);
    assign fill_flag    = fill_q;
    assign frame_flag   = frame_q;
    assign overrun_flag = ovr_q;

    // R4: a flagged end of frame implies a non-empty count
    p_eof_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        eof_present |-> queue_count != '0);

    // R7: an end event taken in the accepting state raises the frame flag
    p_frame_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_end_valid && state_q == RQ_ACCEPT) |=> frame_flag);

    // R8: while discarding and not reading, nothing enters the queue
    p_discard_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RQ_DISCARD && !rd_en) |=> $stable(occupancy));

    // R2: a dropped checksum byte does not change the occupancy
    p_crc_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_byte_valid && rx_byte_is_crc && !cfg_pass_crc && !rx_end_valid && !rd_en)
        |=> $stable(occupancy));

    // R6: occupancy at the threshold forces the fill flag next cycle
    p_fill_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy >= CW'(cfg_fill_level)) |=> fill_flag);

endmodule

// File: tb/hdlc_rx_queue_tb.sv
module hdlc_rx_queue_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_byte_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_byte_is_crc = 1'b0;
    logic       rx_end_valid = 1'b0;
    logic       rx_end_bad_crc = 1'b0;
    logic       rx_end_abort = 1'b0;
    logic       rx_end_bad_count = 1'b0;
    logic       rx_bit_valid = 1'b0;
    logic       rx_bit = 1'b0;
    logic       cfg_pass_crc = 1'b0;
    logic [5:0] cfg_fill_level = 6'd63;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       status_rd = 1'b0;
    logic [6:0] queue_count;
    logic       eof_present, fill_flag, frame_flag, overrun_flag, idle_flag;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hdlc_rx_queue u_dut (
        .clk (clk), .rst_n (rst_n),
        .rx_byte_valid (rx_byte_valid), .rx_byte (rx_byte), .rx_byte_is_crc (rx_byte_is_crc),
        .rx_end_valid (rx_end_valid), .rx_end_bad_crc (rx_end_bad_crc),
        .rx_end_abort (rx_end_abort), .rx_end_bad_count (rx_end_bad_count),
        .rx_bit_valid (rx_bit_valid), .rx_bit (rx_bit),
        .cfg_pass_crc (cfg_pass_crc), .cfg_fill_level (cfg_fill_level),
        .rd_en (rd_en), .rd_data (rd_data), .status_rd (status_rd),
        .queue_count (queue_count), .eof_present (eof_present),
        .fill_flag (fill_flag), .frame_flag (frame_flag),
        .overrun_flag (overrun_flag), .idle_flag (idle_flag)
    );

    // Frame vectors: [15:10] payload bytes, [9:8] checksum bytes, [7] pass,
    // [6] bad crc, [5] abort, [4] bad count, [3:0] payload high nibble
    localparam logic [15:0] VECS [6] = '{
        16'h0E01, 16'h0AC2, 16'h0423, 16'h0114, 16'h1555, 16'h3EE6
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_byte(input logic [7:0] b, input logic is_crc);
        @(negedge clk);
        rx_byte_valid = 1'b1; rx_byte = b; rx_byte_is_crc = is_crc;
        @(negedge clk);
        rx_byte_valid = 1'b0; rx_byte_is_crc = 1'b0;
    endtask

    task automatic end_frame(input logic bc, input logic ab, input logic bn);
        @(negedge clk);
        rx_end_valid = 1'b1; rx_end_bad_crc = bc; rx_end_abort = ab; rx_end_bad_count = bn;
        @(negedge clk);
        rx_end_valid = 1'b0; rx_end_bad_crc = 1'b0; rx_end_abort = 1'b0; rx_end_bad_count = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] v);
        @(negedge clk);
        v = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic stat_read();
        @(negedge clk);
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_bit_valid = 1'b1; rx_bit = b;
        @(negedge clk);
        rx_bit_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        chk("R11 count", queue_count, 0);
        chk("R11 eof", eof_present, 0);
        chk("R11 flags", {fill_flag, frame_flag, overrun_flag, idle_flag}, 0);
        chk("R11 rd_data", rd_data, 0);

        // Table walk: R1 R2 R3 R4 R5 R7
        foreach (VECS[k]) begin
            int n, nc, exp_cnt;
            logic pass;
            logic [7:0] st;
            n    = int'(VECS[k][15:10]);
            nc   = int'(VECS[k][9:8]);
            pass = VECS[k][7];
            st   = {VECS[k][6], VECS[k][5], 1'b0, VECS[k][4], 4'h0};
            cfg_pass_crc = pass;
            stat_read();
            chk("R7 frame flag cleared", frame_flag, 0);
            for (int i = 0; i < n; i++) push_byte({VECS[k][3:0], 4'(i)}, 1'b0);
            for (int j = 0; j < nc; j++) push_byte(8'hC0 | 8'(j), 1'b1);
            end_frame(VECS[k][6], VECS[k][5], VECS[k][4]);
            exp_cnt = n + (pass ? nc : 0) + 1;
            chk("R1 R5 count", queue_count, exp_cnt);
            chk("R4 eof set", eof_present, 1);
            chk("R7 frame flag", frame_flag, 1);
            for (int i = 0; i < n; i++) begin
                read_byte(v);
                chk("R1 payload", v, {VECS[k][3:0], 4'(i)});
            end
            if (pass) begin
                for (int j = 0; j < nc; j++) begin
                    read_byte(v);
                    chk("R2 checksum stored", v, 8'hC0 | 8'(j));
                end
            end
            read_byte(v);
            chk("R3 status byte", v, st);
            chk("R4 eof cleared", eof_present, 0);
            chk("R2 R5 empty after frame", queue_count, 0);
        end
        cfg_pass_crc = 1'b0;

        // R5: several frames queued, count moves between status bytes
        push_byte(8'h11, 1'b0); push_byte(8'h12, 1'b0); end_frame(1'b0, 1'b0, 1'b0);
        push_byte(8'h21, 1'b0); push_byte(8'h22, 1'b0); push_byte(8'h23, 1'b0);
        end_frame(1'b1, 1'b0, 1'b0);
        push_byte(8'h31, 1'b0); push_byte(8'h32, 1'b0);
        chk("R5 first frame count", queue_count, 3);
        for (int i = 0; i < 3; i++) read_byte(v);
        chk("R5 second frame count", queue_count, 4);
        chk("R4 eof with one frame left", eof_present, 1);
        for (int i = 0; i < 3; i++) read_byte(v);
        read_byte(v);
        chk("R3 second status", v, 8'h80);
        chk("R5 open frame count", queue_count, 2);
        chk("R4 no status queued", eof_present, 0);
        read_byte(v); read_byte(v);
        chk("R5 drained", queue_count, 0);

        // R10: empty read
        read_byte(v);
        chk("R10 empty read value", v, 0);
        chk("R10 empty read count", queue_count, 0);
        push_byte(8'h77, 1'b0);
        chk("R10 count after push", queue_count, 1);
        read_byte(v);
        chk("R10 pointers intact", v, 8'h77);

        // R6: fill threshold
        cfg_fill_level = 6'd4;
        stat_read();
        for (int i = 0; i < 3; i++) push_byte(8'(i), 1'b0);
        @(negedge clk);
        chk("R6 below level", fill_flag, 0);
        push_byte(8'h03, 1'b0);
        @(negedge clk);
        chk("R6 at level", fill_flag, 1);
        stat_read();
        chk("R6 held at level", fill_flag, 1);
        read_byte(v);
        chk("R6 sticky below level", fill_flag, 1);
        stat_read();
        chk("R6 cleared", fill_flag, 0);
        for (int i = 0; i < 3; i++) read_byte(v);
        cfg_fill_level = 6'd63;

        // R8: overrun on a full queue
        stat_read();
        for (int i = 0; i < 64; i++) push_byte(8'(i), 1'b0);
        chk("R1 full count", queue_count, 64);
        chk("R8 no overrun yet", overrun_flag, 0);
        push_byte(8'hAA, 1'b0);
        chk("R8 overrun flag", overrun_flag, 1);
        chk("R8 count unchanged", queue_count, 64);
        chk("R8 status marked", eof_present, 1);
        push_byte(8'hBB, 1'b0); push_byte(8'hCC, 1'b0);
        end_frame(1'b1, 1'b0, 1'b0);
        chk("R8 dropped bytes", queue_count, 64);
        chk("R8 dropped end", frame_flag, 0);
        for (int i = 0; i < 63; i++) begin
            read_byte(v);
            if (i == 0 || i == 62) chk("R8 kept bytes", v, i);
        end
        read_byte(v);
        chk("R8 overrun status byte", v, 8'h20);
        chk("R8 empty after drain", queue_count, 0);
        push_byte(8'h5A, 1'b0);
        end_frame(1'b0, 1'b0, 1'b0);
        chk("R8 next frame accepted", queue_count, 2);
        read_byte(v);
        chk("R8 next frame data", v, 8'h5A);
        read_byte(v);
        chk("R8 next frame status", v, 8'h00);
        stat_read();
        chk("R8 overrun cleared", overrun_flag, 0);

        // R9: idle detection
        for (int i = 0; i < 14; i++) send_bit(1'b1);
        chk("R9 fourteen ones", idle_flag, 0);
        send_bit(1'b1);
        chk("R9 fifteen ones", idle_flag, 1);
        send_bit(1'b1);
        chk("R9 sixteen ones", idle_flag, 1);
        send_bit(1'b0);
        chk("R9 zero clears", idle_flag, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule